// File: doc/BRIEF.md
# Clear-on-read interrupt status controller

This block gathers event pulses and level-derived conditions from a line framer into a status register, one bit per cause. Pulse inputs set their bit directly. Edge detectors turn the transmit-line, frame-alignment and alarm-simulation levels into set events. A companion mask register decides which latched bits may raise the interrupt pin and the global summary bit. The host empties the whole register with a single read strobe.

A visibility control changes how masked causes are handled. When it is off, a masked cause is not recorded at all. When it is on, a masked cause is recorded and can be read, but it still cannot reach the pin or the summary. A transmit underrun also asserts a lockout level that holds the transmitter and its FIFO inactive. Only a status read releases the lockout.

Top module: `irq_stat_ctrl`

## Requirements
- R1: While `rd_stb_i` is high, `rd_data_o` shows the current status bits. At the clock edge that ends the strobe cycle, every status bit clears.
- R2: An event that arrives in the same cycle as a read strobe is not part of that read's data, but its bit is set after the edge. An underrun in a read cycle leaves `tx_lock_o` high.
- R3: With `vis_i` low, an event whose bit is set in `mask_i` does not latch.
- R4: With `vis_i` high, a masked event latches and can be read, but it asserts neither `irq_o` nor `gsum_o`.
- R5: `gsum_o` is the OR over all bits of (status AND NOT mask), registered, so it rises one clock after the bit latches. `irq_o` is the same signal, active high by default.
- R6: Bit 2 (line change) sets on a rising edge of `txline_open_i` or on any change of `txline_short_i`. A falling or steady `txline_open_i` sets nothing.
- R7: Bit 4 (alignment regained) sets on a falling edge of `lof_i`. A rising edge sets nothing.
- R8: Bit 4 also sets on a falling edge of `almsim_i` while `lof_i` is low. With `lof_i` high, that edge sets nothing.
- R9: An `ev_txund_i` pulse sets bit 0 and raises `tx_lock_o` at the same edge, whatever the mask. The lockout holds until a read strobe and is low after that edge.
- R10: The pulse inputs map as follows: `ev_txmf_i` to bit 1 (multiframe start), `ev_tprdy_i` to bit 3 (room for a 32-byte block), and `ev_aux_i[k]` to bit 5+k.
- R11: After reset, all status bits, `gsum_o` and `tx_lock_o` are 0, `irq_o` is inactive, and the edge history registers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_txund_i | input | 1 | Transmit underrun pulse |
| ev_txmf_i | input | 1 | Transmit multiframe start pulse |
| ev_tprdy_i | input | 1 | Transmit pool ready pulse |
| ev_aux_i | input | STAT_W-5 | Further framer event pulses |
| txline_open_i | input | 1 | Transmit line open level |
| txline_short_i | input | 1 | Transmit line short level |
| lof_i | input | 1 | Loss of frame alignment level |
| almsim_i | input | 1 | Alarm simulation active level |
| mask_i | input | STAT_W | Per-bit interrupt mask, 1 = masked |
| vis_i | input | 1 | Visibility mode for masked events |
| rd_stb_i | input | 1 | Single-cycle status read strobe |
| rd_data_o | output | STAT_W | Current status bits |
| irq_o | output | 1 | Interrupt pin |
| gsum_o | output | 1 | Global interrupt summary bit |
| tx_lock_o | output | 1 | Transmitter and FIFO lockout |

## Verification
The bench drives single pulses, several pulses in one cycle, and steady levels, and it drives both edge directions on each level input. These patterns show whether the edge logic tells a rising edge from a falling edge, and a change from a steady level. Each cause is tried in three settings: unmasked, masked with visibility off, and masked with visibility on. Comparing the read data with the pin in these settings separates "not latched" from "latched but hidden". Events that land in the same cycle as a read test that no event is lost, for both the status bits and the lockout.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
   // fixed bit positions of the status register
   localparam int BIT_UND   = 0;
   localparam int BIT_MFB   = 1;
   localparam int BIT_LCHG  = 2;
   localparam int BIT_PRDY  = 3;
   localparam int BIT_FREC  = 4;
   localparam int BIT_AUX0  = 5;
   localparam int FIXED_BITS = 5;

   typedef struct packed {
      logic open_q;
      logic short_q;
      logic lof_q;
      logic sim_q;
   } line_hist_t;
endpackage

// File: rtl/irq_line_edges.sv
module irq_line_edges
   import irq_stat_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,
   input  logic short_i,
   input  logic lof_i,
   input  logic sim_i,
   output logic lchg_o,
   output logic frec_o
);
   line_hist_t hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else begin
         hist_q.open_q  <= open_i;
         hist_q.short_q <= short_i;
         hist_q.lof_q   <= lof_i;
         hist_q.sim_q   <= sim_i;
      end
   end

   logic open_rise, short_chg, lof_fall, sim_end_sync;

   assign open_rise    = open_i & ~hist_q.open_q;
   assign short_chg    = short_i ^ hist_q.short_q;
   assign lof_fall     = ~lof_i & hist_q.lof_q;
   assign sim_end_sync = ~sim_i & hist_q.sim_q & ~lof_i;

   assign lchg_o = open_rise | short_chg;
   assign frec_o = lof_fall | sim_end_sync;
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] mask_i,
   input  logic         vis_i,
   input  logic         clr_i,
   output logic [W-1:0] stat_o
);
   for (genvar k = 0; k < W; k++) begin : g_bit
      logic q;
      logic accept;

      // a masked cause is recorded only in visibility mode
      assign accept = set_i[k] & (vis_i | ~mask_i[k]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= (q & ~clr_i) | accept;
      end

      assign stat_o[k] = q;
   end
endmodule

// File: rtl/irq_stat_summary.sv
module irq_stat_summary #(
   parameter int W       = 8,
   parameter bit ACT_LOW = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat_i,
   input  logic [W-1:0] mask_i,
   output logic         gsum_o,
   output logic         irq_o
);
   logic pend_q;
   logic [W-1:0] live;

   assign live = stat_i & ~mask_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= |live;
   end

   assign gsum_o = pend_q;

   if (ACT_LOW) begin : g_pin_low
      assign irq_o = ~pend_q;
   end else begin : g_pin_high
      assign irq_o = pend_q;
   end
endmodule

// File: rtl/irq_tx_lockout.sv
module irq_tx_lockout #(
   parameter bit EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic und_i,
   input  logic clr_i,
   output logic lock_o
);
   if (EN) begin : g_lock
      logic lock_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lock_q <= 1'b0;
         else        lock_q <= und_i | (lock_q & ~clr_i);
      end
      assign lock_o = lock_q;
   end else begin : g_nolock
      assign lock_o = 1'b0;
   end
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
   import irq_stat_pkg::*;
#(
   parameter int STAT_W      = 8,
   parameter bit IRQ_ACT_LOW = 1'b0,
   parameter bit LOCK_EN     = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ev_txund_i,
   input  logic                          ev_txmf_i,
   input  logic                          ev_tprdy_i,
   input  logic [STAT_W-FIXED_BITS-1:0]  ev_aux_i,
   input  logic                          txline_open_i,
   input  logic                          txline_short_i,
   input  logic                          lof_i,
   input  logic                          almsim_i,
   input  logic [STAT_W-1:0]             mask_i,
   input  logic                          vis_i,
   input  logic                          rd_stb_i,
   output logic [STAT_W-1:0]             rd_data_o,
   output logic                          irq_o,
   output logic                          gsum_o,
   output logic                          tx_lock_o
);
   localparam int AUX_W = STAT_W - FIXED_BITS;

   if (STAT_W < FIXED_BITS + 1) begin : g_chk_width
      $error("irq_stat_ctrl: STAT_W must be at least %0d", FIXED_BITS + 1);
   end
   if (STAT_W > 32) begin : g_chk_max
      $error("irq_stat_ctrl: STAT_W above 32 is not supported");
   end

   logic lchg_set, frec_set;
   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] stat;

   irq_line_edges u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .open_i  (txline_open_i),
      .short_i (txline_short_i),
      .lof_i   (lof_i),
      .sim_i   (almsim_i),
      .lchg_o  (lchg_set),
      .frec_o  (frec_set)
   );

   assign set_vec[BIT_UND]  = ev_txund_i;
   assign set_vec[BIT_MFB]  = ev_txmf_i;
   assign set_vec[BIT_LCHG] = lchg_set;
   assign set_vec[BIT_PRDY] = ev_tprdy_i;
   assign set_vec[BIT_FREC] = frec_set;
   for (genvar a = 0; a < AUX_W; a++) begin : g_aux
      assign set_vec[BIT_AUX0 + a] = ev_aux_i[a];
   end

   irq_stat_bank #(.W(STAT_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .mask_i (mask_i),
      .vis_i  (vis_i),
      .clr_i  (rd_stb_i),
      .stat_o (stat)
   );

   irq_stat_summary #(.W(STAT_W), .ACT_LOW(IRQ_ACT_LOW)) u_sum (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (stat),
      .mask_i (mask_i),
      .gsum_o (gsum_o),
      .irq_o  (irq_o)
   );

   irq_tx_lockout #(.EN(LOCK_EN)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .und_i  (ev_txund_i),
      .clr_i  (rd_stb_i),
      .lock_o (tx_lock_o)
   );

   assign rd_data_o = stat;
endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk #(
   parameter int STAT_W  = 8,
   parameter bit LOCK_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_stb_i,
   input logic [STAT_W-1:0] set_vec,
   input logic [STAT_W-1:0] mask_i,
   input logic              vis_i,
   input logic              ev_txund_i,
   input logic              ev_tprdy_i,
   input logic [STAT_W-1:0] rd_data_o,
   input logic              gsum_o,
   input logic              tx_lock_o
);
   // R1
   clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && set_vec == '0) |=> rd_data_o == '0);

   // R2
   no_lost_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && ev_tprdy_i && (vis_i || !mask_i[3])) |=> rd_data_o[3]);

   // R3
   masked_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vis_i |=> ((rd_data_o & ~$past(rd_data_o) & $past(mask_i)) == '0));

   // R4
   masked_no_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_data_o & ~mask_i) == '0) |=> !gsum_o);

   // R9
   lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (LOCK_EN && ev_txund_i) |=> tx_lock_o);

   // R9
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_lock_o && !rd_stb_i) |=> tx_lock_o);

   // R9
   lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_lock_o && rd_stb_i && !ev_txund_i) |=> !tx_lock_o);
endmodule

bind irq_stat_ctrl irq_stat_chk #(.STAT_W(STAT_W), .LOCK_EN(LOCK_EN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_stb_i   (rd_stb_i),
   .set_vec    (set_vec),
   .mask_i     (mask_i),
   .vis_i      (vis_i),
   .ev_txund_i (ev_txund_i),
   .ev_tprdy_i (ev_tprdy_i),
   .rd_data_o  (rd_data_o),
   .gsum_o     (gsum_o),
   .tx_lock_o  (tx_lock_o)
);

// File: tb/sim_irq_stat_ctrl.sv
module sim_irq_stat_ctrl;
   localparam int CLK_PER = 10;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_txund_i = 0, ev_txmf_i = 0, ev_tprdy_i = 0;
   logic [2:0] ev_aux_i = '0;
   logic txline_open_i = 0, txline_short_i = 0, lof_i = 0, almsim_i = 0;
   logic [W-1:0] mask_i = '0;
   logic vis_i = 0, rd_stb_i = 0;
   logic [W-1:0] rd_data_o;
   logic irq_o, gsum_o, tx_lock_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   logic [W-1:0] exp_q[$];
   string        tag_q[$];

   always #(CLK_PER/2) clk = ~clk;

   irq_stat_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .ev_txund_i(ev_txund_i), .ev_txmf_i(ev_txmf_i), .ev_tprdy_i(ev_tprdy_i),
      .ev_aux_i(ev_aux_i),
      .txline_open_i(txline_open_i), .txline_short_i(txline_short_i),
      .lof_i(lof_i), .almsim_i(almsim_i),
      .mask_i(mask_i), .vis_i(vis_i), .rd_stb_i(rd_stb_i),
      .rd_data_o(rd_data_o), .irq_o(irq_o), .gsum_o(gsum_o), .tx_lock_o(tx_lock_o)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // driver: queue the expected read value, then strobe one cycle
   task automatic read_expect(logic [W-1:0] v, string tag);
      exp_q.push_back(v);
      tag_q.push_back(tag);
      rd_stb_i = 1'b1;
      tick();
      rd_stb_i = 1'b0;
   endtask

   // monitor: compare read data a quarter period after the driving edge
   always begin
      @(negedge clk);
      #(CLK_PER/4);
      if (rd_stb_i) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R1: unexpected read, actual %0h expected none", rd_data_o);
         end else begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, rd_data_o, e);
         end
      end
   end

   initial begin
      for (int i = 0; i < 200000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      // R11 reset state
      chk("R11 data", rd_data_o, 0);
      chk("R11 irq", irq_o, 0);
      chk("R11 gsum", gsum_o, 0);
      chk("R11 lock", tx_lock_o, 0);
      read_expect(8'h00, "R11");

      // R10 / R5 multiframe pulse, unmasked
      ev_txmf_i = 1; tick(); ev_txmf_i = 0;
      chk("R10 mfb bit", rd_data_o, 8'h02);
      chk("R5 irq latency", irq_o, 0);
      tick();
      chk("R5 irq", irq_o, 1);
      chk("R5 gsum", gsum_o, 1);
      read_expect(8'h02, "R1");
      chk("R1 cleared", rd_data_o, 0);
      tick();
      chk("R5 irq drop", irq_o, 0);

      // R3 masked, visibility off
      mask_i = 8'h02;
      ev_txmf_i = 1; tick(); ev_txmf_i = 0; tick();
      chk("R3 irq", irq_o, 0);
      read_expect(8'h00, "R3");

      // R4 masked, visibility on
      vis_i = 1;
      ev_txmf_i = 1; tick(); ev_txmf_i = 0; tick();
      chk("R4 irq", irq_o, 0);
      chk("R4 gsum", gsum_o, 0);
      read_expect(8'h02, "R4");
      mask_i = 0; vis_i = 0;

      // R10 several pulses at once
      ev_aux_i = 3'b101; ev_tprdy_i = 1; tick();
      ev_aux_i = 0; ev_tprdy_i = 0;
      read_expect(8'hA8, "R10");

      // R6 line change
      txline_open_i = 1; tick();
      read_expect(8'h04, "R6");
      tick();
      read_expect(8'h00, "R6");
      txline_open_i = 0; tick();
      read_expect(8'h00, "R6");
      txline_short_i = 1; tick();
      read_expect(8'h04, "R6");
      txline_short_i = 0; tick();
      read_expect(8'h04, "R6");

      // R7 alignment flag edges
      lof_i = 1; tick();
      read_expect(8'h00, "R7");
      lof_i = 0; tick();
      read_expect(8'h10, "R7");

      // R8 alarm simulation end
      almsim_i = 1; tick();
      almsim_i = 0; tick();
      read_expect(8'h10, "R8");
      almsim_i = 1; tick();
      lof_i = 1; tick();
      almsim_i = 0; tick();
      read_expect(8'h00, "R8");
      lof_i = 0; tick();
      read_expect(8'h10, "R7");

      // R9 underrun lockout
      ev_txund_i = 1; tick(); ev_txund_i = 0;
      chk("R9 lock set", tx_lock_o, 1);
      chk("R9 bit0", rd_data_o, 8'h01);
      tick(); tick(); tick();
      chk("R9 lock held", tx_lock_o, 1);
      read_expect(8'h01, "R9");
      chk("R9 lock released", tx_lock_o, 0);
      mask_i = 8'h01;
      ev_txund_i = 1; tick(); ev_txund_i = 0;
      chk("R9 lock masked", tx_lock_o, 1);
      read_expect(8'h00, "R9");
      chk("R9 lock released masked", tx_lock_o, 0);
      mask_i = 0;

      // R2 events during a read
      ev_txmf_i = 1; tick(); ev_txmf_i = 0;
      exp_q.push_back(8'h02); tag_q.push_back("R2");
      rd_stb_i = 1; ev_tprdy_i = 1; tick();
      rd_stb_i = 0; ev_tprdy_i = 0;
      read_expect(8'h08, "R2");
      exp_q.push_back(8'h00); tag_q.push_back("R2");
      rd_stb_i = 1; ev_txund_i = 1; tick();
      rd_stb_i = 0; ev_txund_i = 0;
      chk("R2 lock kept", tx_lock_o, 1);
      read_expect(8'h01, "R2");
      chk("R2 lock cleared", tx_lock_o, 0);

      // R5 unmasking a latched bit raises the pin
      mask_i = 8'h02; vis_i = 1;
      ev_txmf_i = 1; tick(); ev_txmf_i = 0; tick();
      chk("R5 hidden", irq_o, 0);
      mask_i = 0; vis_i = 0; tick();
      chk("R5 unmask irq", irq_o, 1);
      read_expect(8'h02, "R5");
      tick();
      chk("R5 irq after read", irq_o, 0);

      tick();
      chk("R1 queue drained", exp_q.size(), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule